// File: doc/BRIEF.md
# Maskable Interrupt Flag Register

This block gathers the event sources of a card host controller into one flag register, combines it with a mask register, and drives a single interrupt line. One-cycle event pulses (data transfer finished, card programming finished, command response ended, card-side interrupt) set sticky flag bits. Software reads the flags, then writes 1s to the flag register to clear the events it has serviced. The two FIFO service requests are level conditions: their flag bits follow the FIFO state directly, and software cannot clear them.

The mask register uses inverted polarity: a 1 disables the matching source, and the register comes out of reset as all ones, so nothing interrupts until software enables it. The interrupt output is the OR of every flag that is unmasked, registered once. Flag reads always return raw values, whatever the mask. The surrounding bus logic only decodes two write strobes that share one data bus, and two read-data ports.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register reads 0x0000 (with both level inputs low), the mask register reads 0xFFFF and the interrupt output is 0.
- R2: A pulse on an event input sets its sticky flag at the next clock edge, and the flag then stays set until it is cleared: bit 0 transfer done, bit 1 programming done, bit 2 response ended, bit 7 card interrupt.
- R3: A flag write clears each sticky bit whose data bit is 1 at the clock edge, and leaves bits whose data bit is 0 unchanged.
- R4: When an event pulse and a clear of the same bit happen in one cycle, the bit is set after that edge.
- R5: Bit 5 (receive FIFO request) and bit 6 (transmit FIFO request) equal their level inputs in the same cycle, and flag writes do not change them.
- R6: A flag write of 0xFFFF clears all sticky bits at once.
- R7: The interrupt output equals, one cycle later, the OR over all bits of flag AND NOT mask.
- R8: The flag read port returns the raw flag values, independent of the mask.
- R9: Bits 3, 4 and 8 to 15 of the flag register read as 0 and ignore writes.
- R10: A mask write stores all 16 data bits at the clock edge, and the mask read port returns them from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_xfer_done | input | 1 | Pulse: data transfer finished (bit 0) |
| ev_prog_done | input | 1 | Pulse: card programming finished (bit 1) |
| ev_resp_end | input | 1 | Pulse: command response ended (bit 2) |
| ev_card_irq | input | 1 | Pulse: interrupt raised by the card (bit 7) |
| rx_req_lvl | input | 1 | Level: receive FIFO needs draining (bit 5) |
| tx_req_lvl | input | 1 | Level: transmit FIFO needs filling (bit 6) |
| flag_we | input | 1 | Write strobe, write-1-to-clear into the flag register |
| mask_we | input | 1 | Write strobe into the mask register |
| wdata | input | 16 | Write data shared by both strobes |
| flag_rdata | output | 16 | Raw flag register contents |
| mask_rdata | output | 16 | Mask register contents |
| irq | output | 1 | Registered interrupt request |

## Verification
The checks assume event inputs are clean single-cycle pulses sampled at the clock edge and that the level inputs change only between edges; the bench drives every input on the falling edge to stay within that. Flag and mask writes may coincide with each other and with events, so random traffic mixes them freely, including writes of 0xFFFF with pending events and writes touching unassigned bits. Directed cases cover the reset values, the event-versus-clear collision and mask suppression.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int IRQF_W = 16;

    localparam int BIT_XFER = 0;
    localparam int BIT_PROG = 1;
    localparam int BIT_RESP = 2;
    localparam int BIT_RXRQ = 5;
    localparam int BIT_TXRQ = 6;
    localparam int BIT_CARD = 7;

    localparam logic [IRQF_W-1:0] STICKY_SET =
        IRQF_W'((1 << BIT_XFER) | (1 << BIT_PROG) | (1 << BIT_RESP) | (1 << BIT_CARD));
    localparam logic [IRQF_W-1:0] LEVEL_SET =
        IRQF_W'((1 << BIT_RXRQ) | (1 << BIT_TXRQ));
endpackage

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
    parameter int           W      = 16,
    parameter logic [W-1:0] STICKY = '0,
    parameter logic [W-1:0] LEVEL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] lvl_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    logic unused_bits;
    assign unused_bits = ^{set_i & ~STICKY, lvl_i & ~LEVEL, clr_i & ~STICKY};

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            logic q;
            // a new event wins over a clear in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b0;
                else        q <= set_i[i] | (q & ~(clr_we_i & clr_i[i]));
            end
            assign flags_o[i] = q;
        end else if (LEVEL[i]) begin : g_level
            assign flags_o[i] = lvl_i[i];
        end else begin : g_none
            assign flags_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irqf_mask_reg.sv
module irqf_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask_o <= '1;
        else if (we_i) mask_o <= wdata_i;
    end
endmodule

// File: rtl/irqf_irq_gen.sv
module irqf_irq_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic pending;
    assign pending = |(flags_i & ~mask_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pending;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_xfer_done,
    input  logic              ev_prog_done,
    input  logic              ev_resp_end,
    input  logic              ev_card_irq,
    input  logic              rx_req_lvl,
    input  logic              tx_req_lvl,
    input  logic              flag_we,
    input  logic              mask_we,
    input  logic [IRQF_W-1:0] wdata,
    output logic [IRQF_W-1:0] flag_rdata,
    output logic [IRQF_W-1:0] mask_rdata,
    output logic              irq
);
    logic [IRQF_W-1:0] set_vec;
    logic [IRQF_W-1:0] lvl_vec;
    logic [IRQF_W-1:0] flags;
    logic [IRQF_W-1:0] mask;

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_XFER] = ev_xfer_done;
        set_vec[BIT_PROG] = ev_prog_done;
        set_vec[BIT_RESP] = ev_resp_end;
        set_vec[BIT_CARD] = ev_card_irq;
        lvl_vec           = '0;
        lvl_vec[BIT_RXRQ] = rx_req_lvl;
        lvl_vec[BIT_TXRQ] = tx_req_lvl;
    end

    irqf_flag_bank #(
        .W      (IRQF_W),
        .STICKY (STICKY_SET),
        .LEVEL  (LEVEL_SET)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .lvl_i    (lvl_vec),
        .clr_we_i (flag_we),
        .clr_i    (wdata),
        .flags_o  (flags)
    );

    irqf_mask_reg #(.W(IRQF_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we),
        .wdata_i (wdata),
        .mask_o  (mask)
    );

    irqf_irq_gen #(.W(IRQF_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .mask_i  (mask),
        .irq_o   (irq)
    );

    assign flag_rdata = flags;
    assign mask_rdata = mask;
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
    import irqf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_xfer_done,
    input logic              ev_prog_done,
    input logic              ev_resp_end,
    input logic              ev_card_irq,
    input logic              rx_req_lvl,
    input logic              tx_req_lvl,
    input logic              flag_we,
    input logic              mask_we,
    input logic [IRQF_W-1:0] wdata,
    input logic [IRQF_W-1:0] flag_rdata,
    input logic [IRQF_W-1:0] mask_rdata,
    input logic              irq
);
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_card_irq |=> flag_rdata[BIT_CARD]); // R2
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata[BIT_RESP] && !(flag_we && wdata[BIT_RESP])) |=> flag_rdata[BIT_RESP]); // R2
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wdata[BIT_PROG] && !ev_prog_done) |=> !flag_rdata[BIT_PROG]); // R3
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wdata[BIT_XFER] && ev_xfer_done) |=> flag_rdata[BIT_XFER]); // R4
    AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rdata[BIT_RXRQ] == rx_req_lvl && flag_rdata[BIT_TXRQ] == tx_req_lvl); // R5
    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 irq == $past(|(flag_rdata & ~mask_rdata))); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata & ~(STICKY_SET | LEVEL_SET)) == '0); // R9
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_rdata == $past(wdata)); // R10
endmodule

bind irq_flag_ctrl irqf_checker u_chk (.*);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_xfer_done = 0, ev_prog_done = 0, ev_resp_end = 0, ev_card_irq = 0;
    logic        rx_req_lvl = 0, tx_req_lvl = 0;
    logic        flag_we = 0, mask_we = 0;
    logic [15:0] wdata = '0;
    logic [15:0] flag_rdata, mask_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] m_st;    // model of sticky bits
    logic [15:0] m_mask;
    logic        m_irq;

    always #2 clk = ~clk;  // 250 MHz

    irq_flag_ctrl u0 (.*);

    function automatic logic [15:0] lvl_bits(input logic rx, input logic tx);
        return (16'(rx) << 5) | (16'(tx) << 6);
    endfunction

    function automatic logic [15:0] ev_bits(input logic [3:0] ev);
        return 16'(ev[0]) | (16'(ev[1]) << 1) | (16'(ev[2]) << 2) | (16'(ev[3]) << 7);
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check, update model across posedge
    task automatic step(input string tag, input logic [3:0] ev, input logic rx, input logic tx,
                        input logic fwe, input logic mwe, input logic [15:0] wd);
        logic [15:0] fl;
        logic        irq_n;
        {ev_card_irq, ev_resp_end, ev_prog_done, ev_xfer_done} = ev;
        rx_req_lvl = rx; tx_req_lvl = tx;
        flag_we = fwe; mask_we = mwe; wdata = wd;
        #1;
        fl = m_st | lvl_bits(rx, tx);
        check16({tag, " R8 flags"}, flag_rdata, fl);
        check16({tag, " R10 mask"}, mask_rdata, m_mask);
        check16({tag, " R7 irq"}, 16'(irq), 16'(m_irq));
        irq_n = |(fl & ~m_mask);
        @(posedge clk);
        m_st  = (m_st & ~(fwe ? wd : 16'h0)) | ev_bits(ev);
        m_mask = mwe ? wd : m_mask;
        m_irq = irq_n;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = '0; m_mask = 16'hFFFF; m_irq = 1'b0;
        // R1: reset values
        check16("R1 flags", flag_rdata, 16'h0000);
        check16("R1 mask", mask_rdata, 16'hFFFF);
        check16("R1 irq", 16'(irq), 16'h0);
        // R2: pulse sets and holds
        step("R2", 4'b0001, 0, 0, 0, 0, 16'h0);
        step("R2", 4'b0000, 0, 0, 0, 0, 16'h0);
        check16("R2 hold", flag_rdata, 16'h0001);
        // R3: writing 0 leaves, writing 1 clears
        step("R3", 4'b1000, 0, 0, 1, 0, 16'h0000);
        check16("R3 zero write", flag_rdata, 16'h0081);
        step("R3", 4'b0000, 0, 0, 1, 0, 16'h0001);
        check16("R3 one write", flag_rdata, 16'h0080);
        // R4: event and clear together
        step("R4", 4'b0100, 0, 0, 1, 0, 16'h0004);
        check16("R4 collide", flag_rdata, 16'h0084);
        // R6 and R5: clear all with levels high
        step("R6", 4'b0011, 1, 1, 0, 0, 16'h0);
        step("R6", 4'b0000, 1, 1, 1, 0, 16'hFFFF);
        check16("R6 clear all", flag_rdata, 16'h0060);
        check16("R5 level kept", flag_rdata & 16'h0060, 16'h0060);
        // R9: unassigned bits ignore writes
        step("R9", 4'b0000, 0, 0, 1, 0, 16'hFF18);
        check16("R9 unused", flag_rdata & 16'hFF18, 16'h0000);
        // R7 / R8: masked source does not interrupt, unmasked one does
        step("R7", 4'b0010, 0, 0, 0, 0, 16'h0);
        step("R7", 4'b0000, 0, 0, 0, 0, 16'h0);
        check16("R7 masked", 16'(irq), 16'h0);
        check16("R8 raw", flag_rdata, 16'h0002);
        step("R10", 4'b0000, 0, 0, 0, 1, 16'hFFFD);
        step("R7", 4'b0000, 0, 0, 0, 0, 16'h0);
        step("R7", 4'b0000, 0, 0, 0, 0, 16'h0);
        check16("R7 unmasked", 16'(irq), 16'h1);
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  ev;
            logic [15:0] wd;
            ev[0] = ($urandom % 6) == 0;
            ev[1] = ($urandom % 6) == 0;
            ev[2] = ($urandom % 6) == 0;
            ev[3] = ($urandom % 6) == 0;
            wd = (($urandom % 8) == 0) ? 16'hFFFF : 16'($urandom);
            step("RND", ev, 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                 ($urandom % 10) == 0, wd);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule